// File: doc/BRIEF.md
# Clock-Ratio Sampling Speed Detector

This block runs on the master clock of an audio converter. It counts how many master clock cycles fall between consecutive rising edges of the word clock, which marks the sample rate. It then sorts that count into one of three sampling speed classes. Each class accepts two ratios: 512 or 768 master clocks per sample means normal speed (32 to 48 kHz), 256 or 384 means double speed (88.2 and 96 kHz), and 128 or 192 means quad speed (176.4 and 192 kHz). The design makes no assumption about the absolute master clock frequency, which can be as high as 36.864 MHz.

The reported speed changes, and the locked flag rises, only after a run of consecutive periods all sort into the same class. A period that matches no ratio drops the lock and keeps the last confirmed code. A word clock that stops long enough to saturate the period counter does the same. A manual override replaces the detected code with a value driven from outside. The word clock arrives asynchronously and passes through a two-flop synchronizer before its edges are counted.

Top module: `wsr_speed_detect`

## Requirements
- R1: After synchronous reset, `speed` reads 2'b00 and `locked` reads 0.
- R2: Periods of 512 or 768 master clocks classify as normal speed, reported as code 2'b00.
- R3: Periods of 256 or 384 master clocks classify as double speed, reported as code 2'b01.
- R4: Periods of 128 or 192 master clocks classify as quad speed, reported as code 2'b10.
- R5: A period matches a ratio when it lies within ±TOL cycles of it (TOL defaults to 2). A period 3 or more cycles away matches nothing.
- R6: `speed` takes a new value and `locked` rises only after LOCK_N (default 4) consecutive measured periods fall in the same class. The first rising word-clock edge after reset or after an overflow only starts a measurement.
- R7: A measured period that matches no ratio clears `locked` and leaves `speed` unchanged.
- R8: If no rising word-clock edge arrives for 2^CNT_W-1 cycles (1023 by default), `locked` clears, `speed` holds, and measurement starts again at the next rising edge.
- R9: While `manual_en` is 1, `speed` equals `manual_speed` and `locked` reads 1. Detection keeps running and its result reappears once `manual_en` returns to 0.
- R10: Periods that alternate between the two ratios of one class count as consecutive periods of that class.
- R11: A matching period whose class differs from the preceding matching periods clears `locked`, restarts the consecutive count, and leaves `speed` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock, asynchronous to `clk` |
| manual_en | input | 1 | Selects the manual speed code |
| manual_speed | input | 2 | Speed code driven out while manual mode is active |
| speed | output | 2 | Speed code: 00 normal, 01 double, 10 quad |
| locked | output | 1 | Detection is stable, or manual mode is active |

## Verification
Assertions check on every cycle that the synchronized edge pulse never lasts two cycles, that the classifier never matches two ratios at once and never produces the reserved code, and that a failed or overflowed measurement leaves the lock cleared and the code held. They also check that the confirmed code changes only in the cycle after a measurement. The bench scenarios are the only place that shows the absolute ratio boundaries (±2 accepted, ±3 rejected), the exact number of periods needed before lock, the re-priming after a stalled word clock, and the return from manual mode to the detected result.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef struct packed {
        logic   hit;
        speed_e speed;
    } class_t;

    localparam int NUM_CLASSES = 3;
    localparam int ALTS        = 2;
    localparam int NUM_RATIOS  = NUM_CLASSES * ALTS;
    localparam int BASE_RATIO  = 64;

    // class index: 0 normal, 1 double, 2 quad; alt 0 -> x2, alt 1 -> x3
    function automatic int ratio_of(input int cls, input int alt);
        return (BASE_RATIO << (NUM_CLASSES - 1 - cls)) * ((alt != 0) ? 3 : 2);
    endfunction

    function automatic speed_e code_of(input int cls);
        case (cls)
            0:       return SPD_NORMAL;
            1:       return SPD_DOUBLE;
            2:       return SPD_QUAD;
            default: return SPD_RSVD;
        endcase
    endfunction

    function automatic logic near(input int meas, input int target, input int tol);
        int d;
        d = (meas > target) ? (meas - target) : (target - meas);
        return (d <= tol);
    endfunction

endpackage

// File: rtl/wsr_sync_edge.sv
module wsr_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);  // R6
endmodule

// File: rtl/wsr_period_counter.sv
module wsr_period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            primed_q   <= 1'b0;
            meas_valid <= 1'b0;
            meas_cnt   <= '0;
            ovf_evt    <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            ovf_evt    <= 1'b0;
            if (rise) begin
                meas_valid <= primed_q;
                meas_cnt   <= cnt_q;
                cnt_q      <= CNT_W'(1);
                primed_q   <= 1'b1;
            end else if (cnt_q == CNT_MAX) begin
                ovf_evt  <= primed_q;
                primed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> !meas_valid);  // R8
endmodule

// File: rtl/wsr_ratio_classifier.sv
module wsr_ratio_classifier
    import wsr_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int TOL   = 2
) (
    input  logic [CNT_W-1:0] count,
    output class_t           result
);
    logic [NUM_RATIOS-1:0] hit_v;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        for (genvar a = 0; a < ALTS; a++) begin : g_alt
            assign hit_v[c*ALTS + a] = near(int'(count), ratio_of(c, a), TOL);
        end
    end

    always_comb begin
        result.hit   = 1'b0;
        result.speed = SPD_NORMAL;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit_v[i]) begin
                result.hit   = 1'b1;
                result.speed = code_of(i / ALTS);
            end
        end
    end

    always_comb begin
        AST_ONE_RATIO: assert ($onehot0(hit_v));                          // R5
        AST_NO_RSVD:   assert (!result.hit || result.speed != SPD_RSVD);  // R2
    end
endmodule

// File: rtl/wsr_lock_filter.sv
module wsr_lock_filter
    import wsr_pkg::*;
#(
    parameter int LOCK_N = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   meas_valid,
    input  class_t meas_class,
    input  logic   ovf_evt,
    output speed_e speed_q,
    output logic   lock_q
);
    localparam int RUN_W = $clog2(LOCK_N + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_N);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_N - 1);

    speed_e           cand_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            speed_q <= SPD_NORMAL;
            lock_q  <= 1'b0;
            cand_q  <= SPD_NORMAL;
            run_q   <= '0;
        end else if (ovf_evt) begin
            lock_q <= 1'b0;
            run_q  <= '0;
        end else if (meas_valid) begin
            if (!meas_class.hit) begin
                lock_q <= 1'b0;
                run_q  <= '0;
            end else if (run_q != '0 && meas_class.speed == cand_q) begin
                if (run_q >= RUN_LAST) begin
                    speed_q <= cand_q;
                    lock_q  <= 1'b1;
                    run_q   <= RUN_FULL;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                cand_q <= meas_class.speed;
                run_q  <= RUN_W'(1);
                lock_q <= 1'b0;
            end
        end
    end

    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && !meas_class.hit) |=> (!lock_q && $stable(speed_q)));  // R7
    AST_OVF_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> (!lock_q && $stable(speed_q)));  // R8
    AST_SPEED_ON_MEAS: assert property (@(posedge clk) disable iff (rst)
        !$stable(speed_q) |-> $past(meas_valid));  // R6
    AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(meas_valid && meas_class.hit));  // R6
endmodule

// File: rtl/wsr_speed_detect.sv
module wsr_speed_detect
    import wsr_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int TOL    = 2,
    parameter int LOCK_N = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wclk_in,
    input  logic       manual_en,
    input  logic [1:0] manual_speed,
    output logic [1:0] speed,
    output logic       locked
);
    logic             rise;
    logic             meas_valid;
    logic             ovf_evt;
    logic [CNT_W-1:0] meas_cnt;
    class_t           meas_class;
    speed_e           det_speed;
    logic             det_lock;

    wsr_sync_edge u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wclk_in),
        .rise     (rise)
    );

    wsr_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .meas_valid (meas_valid),
        .meas_cnt   (meas_cnt),
        .ovf_evt    (ovf_evt)
    );

    wsr_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .count  (meas_cnt),
        .result (meas_class)
    );

    wsr_lock_filter #(.LOCK_N(LOCK_N)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .meas_valid (meas_valid),
        .meas_class (meas_class),
        .ovf_evt    (ovf_evt),
        .speed_q    (det_speed),
        .lock_q     (det_lock)
    );

    assign speed  = manual_en ? manual_speed : det_speed;
    assign locked = manual_en | det_lock;

    AST_DET_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
        (!manual_en && locked) |-> (speed != SPD_RSVD));  // R9
endmodule

// File: tb/wsr_speed_detect_tb.sv
module wsr_speed_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wclk_in = 1'b0;
    logic       manual_en = 1'b0;
    logic [1:0] manual_speed = 2'b00;
    logic [1:0] speed;
    logic       locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsr_speed_detect u_dut (
        .clk          (clk),
        .rst          (rst),
        .wclk_in      (wclk_in),
        .manual_en    (manual_en),
        .manual_speed (manual_speed),
        .speed        (speed),
        .locked       (locked)
    );

    task automatic chk(input string req, input logic [1:0] exp_spd, input logic exp_lock);
        checks++;
        if (speed !== exp_spd || locked !== exp_lock) begin
            fails++;
            $display("FAIL %s: speed=%b locked=%b expected speed=%b locked=%b",
                     req, speed, locked, exp_spd, exp_lock);
        end
    endtask

    // k word-clock periods of n master clocks, each starting with a rising edge
    task automatic run_periods(input int n, input int k);
        for (int i = 0; i < k; i++) begin
            wclk_in = 1'b1;
            repeat (n/2) @(negedge clk);
            wclk_in = 1'b0;
            repeat (n - n/2) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", 2'b00, 1'b0);
    endtask

    task automatic t_normal_lock();
        run_periods(512, 4);
        chk("R6 three periods not enough", 2'b00, 1'b0);
        run_periods(512, 1);
        chk("R2 R6 normal locks after four", 2'b00, 1'b1);
    endtask

    task automatic t_tolerance();
        run_periods(514, 5);
        chk("R5 ratio+2 accepted", 2'b00, 1'b1);
        run_periods(510, 5);
        chk("R5 ratio-2 accepted", 2'b00, 1'b1);
        run_periods(515, 2);
        chk("R5 R7 ratio+3 rejected, speed held", 2'b00, 1'b0);
        run_periods(512, 5);
        chk("R6 relock after miss", 2'b00, 1'b1);
        run_periods(509, 2);
        chk("R5 ratio-3 rejected", 2'b00, 1'b0);
    endtask

    task automatic t_quad();
        run_periods(128, 2);
        chk("R6 single quad period does not switch", 2'b00, 1'b0);
        run_periods(128, 3);
        chk("R4 quad 128 locks", 2'b10, 1'b1);
        run_periods(192, 5);
        chk("R4 quad 192 stays locked", 2'b10, 1'b1);
    endtask

    task automatic t_double();
        run_periods(256, 2);
        chk("R11 class change unlocks, holds quad", 2'b10, 1'b0);
        run_periods(384, 3);
        chk("R3 R10 double via 256 then 384", 2'b01, 1'b1);
    endtask

    task automatic t_alternate();
        run_periods(768, 1);
        run_periods(512, 1);
        chk("R11 normal after double unlocks", 2'b01, 1'b0);
        for (int i = 0; i < 3; i++) begin
            run_periods(768, 1);
            run_periods(512, 1);
        end
        chk("R2 R10 alternating 512/768 locks normal", 2'b00, 1'b1);
    endtask

    task automatic t_overflow();
        run_periods(384, 5);
        chk("R3 double 384 locks", 2'b01, 1'b1);
        repeat (1100) @(negedge clk);
        chk("R8 stalled word clock unlocks, holds code", 2'b01, 1'b0);
        run_periods(256, 4);
        chk("R8 first edge only primes", 2'b01, 1'b0);
        run_periods(256, 1);
        chk("R8 relock after restart", 2'b01, 1'b1);
    endtask

    task automatic t_manual();
        manual_en    = 1'b1;
        manual_speed = 2'b11;
        @(negedge clk);
        chk("R9 manual code 11", 2'b11, 1'b1);
        manual_speed = 2'b10;
        run_periods(768, 3);
        chk("R9 manual overrides detection", 2'b10, 1'b1);
        run_periods(768, 3);
        manual_en = 1'b0;
        @(negedge clk);
        chk("R9 release shows detected normal", 2'b00, 1'b1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_normal_lock();
        t_tolerance();
        t_quad();
        t_double();
        t_alternate();
        t_overflow();
        t_manual();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule